// File: doc/BRIEF.md
# Peripheral Register Target

This block is the target side of a simple peripheral valid/acknowledge link. It holds a small array of word registers. An initiator raises a valid line together with a word address, per-byte enables, a read/write command and write data. Request and response travel on the same handshake. The target waits a fixed number of cycles, then drives the response and raises its acknowledge for exactly one cycle. A cell moves at the clock edge where valid and acknowledge are both high.

Writes change only the byte lanes whose enable bit is set. Reads return the register bytes of the enabled lanes and zero in every other lane. An address that falls beyond the register array is answered with an error code and touches nothing. The block sits behind a bus wrapper, or it connects directly to one peripheral initiator.

Top module: `pvt_target`

## Requirements
- R1: After reset the acknowledge is low, the read data and error outputs are zero, and every register reads back as zero.
- R2: The acknowledge is never raised unless valid was sampled high at the edge that raises it. While valid stays low the acknowledge stays low.
- R3: With WAIT_CYC wait states, the acknowledge rises at the clock edge that comes WAIT_CYC edges after the first edge that samples valid high. With zero wait states it rises at that first edge.
- R4: The acknowledge stays high for exactly one cycle and is low in the cycle after every transfer.
- R5: A write to register index A (address value A, word addressed) replaces byte i (bits 8i+7:8i) only when enable bit i is set. All other bytes keep their value.
- R6: A read returns byte i of register A in lane i when enable bit i is set, and zero in every lane whose enable bit is clear.
- R7: A write in range is answered with error code 0 and all-zero read data.
- R8: An address of NUM_REGS (8) or more is answered with error code 1 and zero read data, and no register changes. An address in range gives error code 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_val | input | 1 | Request valid from the initiator |
| req_addr | input | ADDR_W | Word address of the cell |
| req_be | input | NUM_BYTES | Byte-lane enables |
| req_rd | input | 1 | 1 = read, 0 = write |
| req_wdata | input | 8*NUM_BYTES | Write data |
| rsp_ack | output | 1 | Acknowledge: response is valid |
| rsp_rdata | output | 8*NUM_BYTES | Read data, masked by lane enables |
| rsp_err | output | ERR_W | Response error code (0 ok, 1 out of range) |

## Verification
The assertions check on every cycle that the acknowledge only rises after valid was sampled high, that it never lasts longer than one cycle, that an error response carries zero data and a write response carries zero data, and that the register array holds still in any cycle that has no write. The exact wait-state count, the byte-lane merge on writes, the lane masking on reads, the clearing by reset, and the fact that an out-of-range write does not spill into an aliased register are value questions. Only the bench scenarios show them, by writing known patterns and reading them back through the port.

// File: rtl/pvt_pkg.sv
package pvt_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_ACK  = 2'd2
    } pvt_state_e;

    localparam int unsigned ERR_OK    = 0;
    localparam int unsigned ERR_RANGE = 1;

endpackage

// File: rtl/pvt_ctrl.sv
module pvt_ctrl
    import pvt_pkg::*;
#(
    parameter int unsigned WAIT_CYC = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic val_i,
    output logic ack_o,
    output logic launch_o
);

    localparam int unsigned CNT_W = (WAIT_CYC > 1) ? $clog2(WAIT_CYC) : 1;

    typedef struct packed {
        pvt_state_e       st;
        logic [CNT_W-1:0] cnt;
    } ctrl_s;

    ctrl_s cur_q, nxt_d;

    always_comb begin
        nxt_d    = cur_q;
        launch_o = 1'b0;
        case (cur_q.st)
            ST_IDLE: begin
                if (val_i) begin
                    if (WAIT_CYC == 0) begin
                        nxt_d.st = ST_ACK;
                        launch_o = 1'b1;
                    end else begin
                        nxt_d.st  = ST_WAIT;
                        nxt_d.cnt = '0;
                    end
                end
            end
            ST_WAIT: begin
                if (!val_i) begin
                    nxt_d.st = ST_IDLE;
                end else if (cur_q.cnt == CNT_W'(WAIT_CYC - 1)) begin
                    nxt_d.st = ST_ACK;
                    launch_o = 1'b1;
                end else begin
                    nxt_d.cnt = cur_q.cnt + 1'b1;
                end
            end
            default: begin
                nxt_d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q <= '{st: ST_IDLE, cnt: '0};
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign ack_o = (cur_q.st == ST_ACK);

    // R2: acknowledge only follows a sampled request
    a_r2_ack_needs_val: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ack_o) |-> $past(val_i));

    // R4: acknowledge lasts one cycle
    a_r4_ack_single: assert property (@(posedge clk) disable iff (!rst_n)
        ack_o |=> !ack_o);

endmodule

// File: rtl/pvt_regfile.sv
module pvt_regfile #(
    parameter int unsigned NUM_REGS  = 8,
    parameter int unsigned NUM_BYTES = 4,
    parameter int unsigned IDX_W     = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   we_i,
    input  logic [IDX_W-1:0]       idx_i,
    input  logic [NUM_BYTES-1:0]   be_i,
    input  logic [8*NUM_BYTES-1:0] wdata_i,
    output logic [8*NUM_BYTES-1:0] rdata_o
);

    localparam int unsigned DW = 8 * NUM_BYTES;

    typedef logic [NUM_REGS-1:0][DW-1:0] bank_t;

    bank_t bank_q, bank_d;

    always_comb begin
        bank_d = bank_q;
        if (we_i) begin
            for (int b = 0; b < NUM_BYTES; b++) begin
                if (be_i[b]) begin
                    bank_d[idx_i][8*b +: 8] = wdata_i[8*b +: 8];
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bank_q <= '0;
        end else begin
            bank_q <= bank_d;
        end
    end

    assign rdata_o = bank_q[idx_i];

    // R8: no write strobe, no change anywhere in the array
    a_r8_bank_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(we_i) |-> $stable(bank_q));

endmodule

// File: rtl/pvt_target.sv
module pvt_target
    import pvt_pkg::*;
#(
    parameter int unsigned ADDR_W    = 8,
    parameter int unsigned NUM_REGS  = 8,
    parameter int unsigned NUM_BYTES = 4,
    parameter int unsigned ERR_W     = 2,
    parameter int unsigned WAIT_CYC  = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   req_val,
    input  logic [ADDR_W-1:0]      req_addr,
    input  logic [NUM_BYTES-1:0]   req_be,
    input  logic                   req_rd,
    input  logic [8*NUM_BYTES-1:0] req_wdata,
    output logic                   rsp_ack,
    output logic [8*NUM_BYTES-1:0] rsp_rdata,
    output logic [ERR_W-1:0]       rsp_err
);

    localparam int unsigned DW    = 8 * NUM_BYTES;
    localparam int unsigned IDX_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;

    typedef struct packed {
        logic [DW-1:0]    rdata;
        logic [ERR_W-1:0] err;
    } rsp_s;

    rsp_s rsp_q, rsp_d;

    logic          launch;
    logic          in_range;
    logic          wr_en;
    logic [DW-1:0] reg_word;
    logic [DW-1:0] masked_word;

    assign in_range = ({1'b0, req_addr} < (ADDR_W + 1)'(NUM_REGS));
    assign wr_en    = launch && !req_rd && in_range;

    pvt_ctrl #(.WAIT_CYC(WAIT_CYC)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .val_i    (req_val),
        .ack_o    (rsp_ack),
        .launch_o (launch)
    );

    pvt_regfile #(
        .NUM_REGS  (NUM_REGS),
        .NUM_BYTES (NUM_BYTES),
        .IDX_W     (IDX_W)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (wr_en),
        .idx_i   (req_addr[IDX_W-1:0]),
        .be_i    (req_be),
        .wdata_i (req_wdata),
        .rdata_o (reg_word)
    );

    for (genvar b = 0; b < NUM_BYTES; b++) begin : g_lane
        assign masked_word[8*b +: 8] =
            (req_rd && in_range && req_be[b]) ? reg_word[8*b +: 8] : 8'h00;
    end

    always_comb begin
        rsp_d = rsp_q;
        if (launch) begin
            rsp_d.rdata = masked_word;
            rsp_d.err   = in_range ? ERR_W'(ERR_OK) : ERR_W'(ERR_RANGE);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_q <= '0;
        end else begin
            rsp_q <= rsp_d;
        end
    end

    assign rsp_rdata = rsp_q.rdata;
    assign rsp_err   = rsp_q.err;

    // R8: an error response carries no data
    a_r8_err_no_data: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_ack && rsp_err != '0) |-> rsp_rdata == '0);

    // R7: a write answer carries no data
    a_r7_write_zero: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(rsp_ack) && !$past(req_rd)) |-> rsp_rdata == '0);

endmodule

// File: tb/pvt_target_tb.sv
`timescale 1ns/1ps
module pvt_target_tb;

    localparam int WAIT = 2;
    localparam int NV   = 15;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_val = 1'b0;
    logic [7:0]  req_addr = '0;
    logic [3:0]  req_be = '0;
    logic        req_rd = 1'b0;
    logic [31:0] req_wdata = '0;
    logic        rsp_ack;
    logic [31:0] rsp_rdata;
    logic [1:0]  rsp_err;

    int n_chk = 0;
    int n_err = 0;

    always #2.5 clk = ~clk;

    pvt_target #(.WAIT_CYC(WAIT)) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_val   (req_val),
        .req_addr  (req_addr),
        .req_be    (req_be),
        .req_rd    (req_rd),
        .req_wdata (req_wdata),
        .rsp_ack   (rsp_ack),
        .rsp_rdata (rsp_rdata),
        .rsp_err   (rsp_err)
    );

    // {rd, addr, be, wdata, exp_rdata, exp_err}
    localparam logic [78:0] VEC [NV] = '{
        {1'b0, 8'd0,   4'hF, 32'h11223344, 32'h00000000, 2'd0},
        {1'b1, 8'd0,   4'hF, 32'h0,        32'h11223344, 2'd0},
        {1'b0, 8'd3,   4'h5, 32'hAABBCCDD, 32'h00000000, 2'd0},
        {1'b1, 8'd3,   4'hF, 32'h0,        32'h00BB00DD, 2'd0},
        {1'b1, 8'd3,   4'h4, 32'h0,        32'h00BB0000, 2'd0},
        {1'b0, 8'd9,   4'hF, 32'hFFFFFFFF, 32'h00000000, 2'd1},
        {1'b1, 8'd9,   4'hF, 32'h0,        32'h00000000, 2'd1},
        {1'b1, 8'd1,   4'hF, 32'h0,        32'h00000000, 2'd0},
        {1'b0, 8'd7,   4'h8, 32'h5A000000, 32'h00000000, 2'd0},
        {1'b1, 8'd7,   4'hF, 32'h0,        32'h5A000000, 2'd0},
        {1'b1, 8'd7,   4'h3, 32'h0,        32'h00000000, 2'd0},
        {1'b0, 8'd0,   4'h2, 32'h0000EE00, 32'h00000000, 2'd0},
        {1'b1, 8'd0,   4'hF, 32'h0,        32'h1122EE44, 2'd0},
        {1'b1, 8'd0,   4'h0, 32'h0,        32'h00000000, 2'd0},
        {1'b1, 8'd255, 4'hF, 32'h0,        32'h00000000, 2'd1}
    };

    localparam string TAG [NV] = '{
        "R7", "R6", "R7", "R5", "R6", "R8", "R8", "R8",
        "R7", "R5", "R6", "R7", "R5", "R6", "R8"
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic xfer(input logic rd, input logic [7:0] a, input logic [3:0] be,
                        input logic [31:0] wd, output logic [31:0] rdo,
                        output logic [1:0] eo, output int waited,
                        output logic ack_after);
        @(negedge clk);
        req_val = 1'b1; req_rd = rd; req_addr = a; req_be = be; req_wdata = wd;
        waited = 0;
        do begin
            @(negedge clk);
            waited++;
        end while (!rsp_ack && waited < 50);
        rdo = rsp_rdata;
        eo  = rsp_err;
        @(negedge clk);
        ack_after = rsp_ack;
        req_val = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog: actual expired expected done");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        logic [31:0] rd;
        logic [1:0]  e;
        int          w;
        logic        aa;

        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1", {31'd0, rsp_ack}, 32'd0);
        chk("R1", rsp_rdata, 32'd0);
        chk("R1", {30'd0, rsp_err}, 32'd0);
        rst_n = 1'b1;

        // R2: idle link, acknowledge stays low
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            chk("R2", {31'd0, rsp_ack}, 32'd0);
        end

        // R1: registers cleared
        xfer(1'b1, 8'd5, 4'hF, 32'h0, rd, e, w, aa);
        chk("R1", rd, 32'd0);

        for (int i = 0; i < NV; i++) begin
            xfer(VEC[i][78], VEC[i][77:70], VEC[i][69:66], VEC[i][65:34], rd, e, w, aa);
            chk(TAG[i], rd, VEC[i][33:2]);
            chk(VEC[i][1:0] != 0 ? "R8" : TAG[i], {30'd0, e}, {30'd0, VEC[i][1:0]});
            chk("R3", w, WAIT + 1);
            chk("R4", {31'd0, aa}, 32'd0);
        end

        // R1: reset mid-run clears the array again
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1", {31'd0, rsp_ack}, 32'd0);
        rst_n = 1'b1;
        xfer(1'b1, 8'd0, 4'hF, 32'h0, rd, e, w, aa);
        chk("R1", rd, 32'd0);
        xfer(1'b1, 8'd7, 4'hF, 32'h0, rd, e, w, aa);
        chk("R1", rd, 32'd0);

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule